// File: doc/BRIEF.md
# Aligned Word Load/Store Unit

This unit connects a simple processor datapath to a byte-addressable memory for whole-word loads and stores. A request gives a base register value and a signed 16-bit displacement. The unit adds the two to form the effective address. It checks that the address falls on a word boundary. If it does, the unit drives a 32-bit memory port with an enable, a write strobe and per-byte write enables.

The memory port answers a read within the same cycle. Loaded words are captured in a register and handed back to the register-write side one cycle after the request, together with a valid strobe. A request whose effective address is not a multiple of four never reaches memory. Instead, the unit raises a one-cycle error pulse in the slot where a load result would have appeared. The unit accepts one request per cycle and has no stalls.

Top module: `lsu_word_unit`

## Requirements
- R1: While `req_valid` is high, `mem_addr` equals `base_val` plus the sign-extended `disp`, taken modulo 2^32, in the same cycle.
- R2: An aligned store (`req_valid`=1, `req_store`=1, address bits [1:0] = 00) drives `mem_en`=1, `mem_we`=1 and `mem_be`=4'b1111 in the same cycle. It also drives `mem_wdata` equal to `store_data`, packed little-endian: byte lane k, which is `mem_be[k]`, carries bits [8k+7:8k] of the word at byte address EA+k.
- R3: An aligned load (`req_store`=0) drives `mem_en`=1, `mem_we`=0, `mem_be`=0 and `mem_wdata`=0 in the same cycle.
- R4: One cycle after an aligned load, `ld_valid` is 1 and `ld_data` equals the word the memory returned for that address. `err` is 0 in that cycle.
- R5: A misaligned request (address bits [1:0] not 00) drives `mem_en`, `mem_we` and `mem_be` to zero, so memory is left unchanged.
- R6: One cycle after each misaligned request, `err` is 1 for exactly that cycle and `ld_valid` is 0. `err` is 0 in every other cycle.
- R7: With `req_valid` low, `mem_en`, `mem_we`, `mem_be` and `mem_wdata` are zero. In the next cycle `ld_valid` and `err` are 0.
- R8: A synchronous active-low reset clears `ld_valid`, `err` and `ld_data` to zero.
- R9: `ld_data` holds its value in every cycle in which `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Word to store |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| mem_addr | output | 32 | Byte address to memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Memory write data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Loaded word |
| err | output | 1 | Bus-error pulse for a misaligned access |

## Verification
The assertions check on every cycle that:
- a write always carries the full byte mask;
- a misaligned address never enables memory;
- an error pulse follows exactly one misaligned request and never overlaps a load result;
- the loaded word stays stable between results.

Only the bench's scenarios can show that the effective address wraps correctly for negative displacements and large bases. The same holds for the little-endian lane placement, which the bench confirms by reading stored words back. Finally, the bench shows that misaligned stores leave the previously written contents intact.

// File: rtl/lsu_pkg.sv
// Package: shared types and default widths for the word load/store unit.
// Assumes a power-of-two byte count per data word.
package lsu_pkg;

    localparam int LSU_ADDR_W = 32;
    localparam int LSU_DATA_W = 32;
    localparam int LSU_DISP_W = 16;

    // Classification of the request in the current cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_FAULT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/lsu_agen.sv
// Address generator: sign-extends the displacement, adds it to the base and
// flags addresses that are not on a word boundary.
// Assumes DISP_W < ADDR_W and DATA_W a power-of-two multiple of 8.
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              misaligned
);
    localparam int BYTES    = DATA_W / 8;
    localparam int OFF_BITS = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int EXT_W    = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    // Widen the displacement by replicating its sign bit.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    // Add base and widened displacement; the result wraps modulo 2^ADDR_W.
    always_comb begin
        eff_addr = base_val + disp_ext;
    end

    // A word access is legal only when the low offset bits are zero.
    always_comb begin
        misaligned = |eff_addr[OFF_BITS-1:0];
    end

endmodule

// File: rtl/lsu_memdrv.sv
// Memory port driver: turns the request class into enable, write strobe,
// byte enables and write data. Lanes are little-endian, so lane k carries
// bits [8k+7:8k]. Assumes the memory samples the port on the rising edge.
module lsu_memdrv
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] store_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int BYTES = DATA_W / 8;

    logic is_store;

    // Present the effective address to memory unchanged.
    always_comb begin
        mem_addr = eff_addr;
    end

    // Enable memory only for aligned loads and stores.
    always_comb begin
        is_store = (kind == ACC_STORE);
        mem_en   = (kind == ACC_LOAD) || is_store;
        mem_we   = is_store;
    end

    // One enable bit and one data lane per byte.
    for (genvar lane = 0; lane < BYTES; lane++) begin : g_lane
        // Drive this byte lane only during a store.
        always_comb begin
            mem_be[lane]            = is_store;
            mem_wdata[lane*8 +: 8]  = is_store ? store_data[lane*8 +: 8] : 8'h00;
        end
    end

    // R2
    store_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && (mem_be == {BYTES{1'b1}})));

    // R3
    no_mask_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == '0));

endmodule

// File: rtl/lsu_resp.sv
// Response stage: registers load data and the valid strobe, and produces the
// one-cycle bus-error pulse. Assumes read data arrives in the request cycle.
module lsu_resp
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              err
);

    // Capture the strobes for the next cycle; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            ld_valid <= (kind == ACC_LOAD);
            err      <= (kind == ACC_FAULT);
        end
    end

    // Latch the read word only on an aligned load; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_data <= '0;
        end else if (kind == ACC_LOAD) begin
            ld_data <= mem_rdata;
        end
    end

    // R6
    err_excludes_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !ld_valid);

    // R9
    ld_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> $stable(ld_data));

endmodule

// File: rtl/lsu_word_unit.sv
// Top: aligned word load/store unit. One request per cycle, no stalls.
// Misaligned requests never reach memory and give a one-cycle error pulse
// in the following cycle. Assumes a memory with same-cycle read data.
module lsu_word_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = LSU_ADDR_W,
    parameter int DATA_W = LSU_DATA_W,
    parameter int DISP_W = LSU_DISP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [DISP_W-1:0]   disp,
    input  logic [DATA_W-1:0]   store_data,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_en,
    output logic                mem_we,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_data,
    output logic                err
);
    localparam int BYTES    = DATA_W / 8;
    localparam int OFF_BITS = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [ADDR_W-1:0] eff_addr;
    logic              misaligned;
    acc_kind_e         kind;

    lsu_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) u_agen (
        .base_val   (base_val),
        .disp       (disp),
        .eff_addr   (eff_addr),
        .misaligned (misaligned)
    );

    // Classify the current request; misalignment overrides load/store.
    always_comb begin
        if (!req_valid)      kind = ACC_IDLE;
        else if (misaligned) kind = ACC_FAULT;
        else if (req_store)  kind = ACC_STORE;
        else                 kind = ACC_LOAD;
    end

    lsu_memdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_memdrv (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .eff_addr   (eff_addr),
        .store_data (store_data),
        .mem_addr   (mem_addr),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata)
    );

    lsu_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .err       (err)
    );

    // R5
    misaligned_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mem_addr[OFF_BITS-1:0] != '0)) |-> (!mem_en && !mem_we && (mem_be == '0)));

    // R6
    err_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mem_addr[OFF_BITS-1:0] != '0)) |=> err);

    // R4
    load_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (ld_valid && !err));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_en && !mem_we && (mem_be == '0) && (mem_wdata == '0)));

endmodule

// File: tb/tb_lsu_word_unit.sv
// Bench: behavioural reference model compared on every clock.
module tb_lsu_word_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] base_val = '0;
    logic [15:0] disp = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr;
    logic        mem_en, mem_we, ld_valid, err;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, ld_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] bmem [0:15];   // memory written by the DUT
    logic [31:0] rmem [0:15];   // reference copy kept by the model

    logic        exp_lv = 1'b0;
    logic        exp_err = 1'b0;
    logic [31:0] exp_ld = '0;

    always #4 clk = ~clk;       // 125 MHz

    lsu_word_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .base_val(base_val), .disp(disp), .store_data(store_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_en(mem_en),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .err(err)
    );

    assign mem_rdata = bmem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[5:2]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request cycle: check last cycle's results, drive, check the port.
    task automatic step(input bit v, input bit st, input logic [31:0] b,
                        input logic [15:0] d, input logic [31:0] sd);
        logic [31:0] ea;
        bit mis;
        @(negedge clk);
        check("R4/R6 ld_valid", {31'd0, ld_valid}, {31'd0, exp_lv});
        check("R6 err", {31'd0, err}, {31'd0, exp_err});
        check("R4/R9 ld_data", ld_data, exp_ld);
        req_valid = v; req_store = st; base_val = b; disp = d; store_data = sd;
        #1;
        ea  = b + 32'(signed'(d));
        mis = (ea[1:0] != 2'b00);
        exp_lv = 1'b0; exp_err = 1'b0;
        if (!v) begin
            check("R7 idle port", {mem_en, mem_we, mem_be, mem_wdata[25:0]},
                  {6'd0, 26'd0});
            check("R7 idle wdata", mem_wdata, 32'd0);
        end else begin
            check("R1 addr", mem_addr, ea);
            if (mis) begin
                check("R5 no touch", {29'd0, mem_en, mem_we, |mem_be}, 32'd0);
                exp_err = 1'b1;
            end else if (st) begin
                check("R2 store ctl", {26'd0, mem_en, mem_we, mem_be}, {26'd0, 6'b111111});
                check("R2 store data", mem_wdata, sd);
                rmem[ea[5:2]] = sd;
            end else begin
                check("R3 load ctl", {26'd0, mem_en, mem_we, mem_be}, {26'd0, 6'b100000});
                check("R3 load wdata", mem_wdata, 32'd0);
                exp_lv = 1'b1;
                exp_ld = rmem[ea[5:2]];
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 5000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            bmem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
            rmem[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 ld_valid", {31'd0, ld_valid}, 32'd0);
        check("R8 err", {31'd0, err}, 32'd0);
        check("R8 ld_data", ld_data, 32'd0);
        rst_n = 1'b1;
        // Plain loads, positive displacement.
        step(1, 0, 32'h0000_1000, 16'h0004, '0);
        step(1, 0, 32'h0000_1000, 16'h0010, '0);
        // Negative displacement and wraparound (R1).
        step(1, 0, 32'h0000_0020, 16'hFFF8, '0);
        step(1, 0, 32'h0000_0004, 16'hFFF8, '0);
        step(0, 0, '0, '0, '0);
        // Stores, little-endian lanes read back (R2, R4).
        step(1, 1, 32'h8000_0000, 16'h0008, 32'h4433_2211);
        step(1, 0, 32'h8000_0008, 16'h0000, '0);
        step(1, 1, 32'hFFFF_FFFC, 16'h0010, 32'hDEAD_BEEF);
        step(1, 0, 32'h0000_0000, 16'h000C, '0);
        // Misaligned stores and loads for each offset (R5, R6).
        step(1, 1, 32'h8000_0009, 16'h0000, 32'h1111_1111);
        step(1, 1, 32'h8000_0008, 16'h0002, 32'h2222_2222);
        step(1, 0, 32'h8000_0008, 16'hFFFF, '0);
        step(0, 0, '0, '0, '0);
        step(1, 0, 32'h8000_0008, 16'h0000, '0);   // R5: word still intact
        step(1, 1, 32'h0000_0003, 16'h0001, 32'h5555_AAAA);  // aligned via sum
        step(1, 0, 32'h0000_0004, 16'h0000, '0);
        // Idle after load: ld_data holds (R9).
        step(0, 1, 32'h0000_0001, 16'h0000, 32'hFFFF_FFFF);
        step(0, 0, '0, '0, '0);
        // Mixed sweep of aligned and misaligned traffic.
        for (int k = 0; k < 64; k++) begin
            step(1, k[0], 32'h0000_0100 + k, 16'(k * 5 - 40), 32'hC0DE_0000 + k);
        end
        for (int k = 0; k < 16; k++) begin
            step(1, 0, 32'h0000_0000, 16'(k * 4), '0);
        end
        step(0, 0, '0, '0, '0);
        step(0, 0, '0, '0, '0);
        finish_run();
    end

endmodule